// File: doc/BRIEF.md
# Two-Way Pipelined Instruction Cache

This block sits between a processor's program counter stage and its program memory and keeps recently fetched instruction words in four lines arranged as two sets of two ways. An access enters in the PC stage. There, the set index taken from the fetch address reads the tag and valid state of both ways, and a per-way hit is formed. One clock later, in the fetch stage, the block does one of two things. On a hit it returns the word held by the hitting way. On a miss it enables program memory, forwards the returned word towards decode, and stores it in the way named by a single replacement bit.

Writes to program memory travel through the same two stages. A write never counts as a hit and always goes out to memory. Any copy of the written address that is already cached is updated in place. A write does not claim a line, and it leaves the decode output untouched. The replacement bit flips on every fetch-stage hit and otherwise stays put.

A fill takes effect at the end of the fetch cycle. If the PC stage in that same cycle finds a hit on the exact line that the fill is about to overwrite, the block reports that access as a miss. It therefore never returns a word from an evicted line.

Top module: `icache_2way`

## Requirements
- R1: A synchronous active-low reset clears every valid bit, the replacement bit (to way 0), the decode output (to zero), `hit_o` and `mem_en_o`. The first read after reset is a miss.
- R2: Address bit 0 selects the set and bits 15 to 1 form the tag. A read hits only if a valid line in that set holds the same tag, so addresses that differ only in the set bit, or only in tag bits, do not hit each other's lines.
- R3: The cycle after a read is presented, `mem_en_o` is the inverse of `hit_o`, `mem_we_o` is 0 and `mem_addr_o` equals the read address.
- R4: On a read hit, `hit_o` is 1 in the fetch cycle, memory is not enabled, and the cached word reaches `dec_instr_o` one clock later.
- R5: On a read miss, the word on `mem_rdata_i` reaches `dec_instr_o` one clock after the fetch cycle. It is stored, with its tag and a set valid bit, in the way given by the replacement bit. Valid bits are set only by such fills, so both ways of a set can hold lines at once.
- R6: The replacement bit inverts on every fetch-stage hit and holds on misses and writes. Way 0 receives the first fill after reset.
- R7: A write is never a hit. The cycle after it is presented, `mem_en_o` and `mem_we_o` are 1 and `mem_addr_o`/`mem_wdata_o` carry its address and data. A cached copy of that address takes the new data, and an uncached address is not allocated.
- R8: A PC-stage hit on the way and set that a fetch-stage fill overwrites at the end of the same cycle is reported as a miss.
- R9: `dec_instr_o` changes only after read accesses and holds its value across a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_addr_i | input | 16 | Access address in the PC stage |
| pc_we_i | input | 1 | The PC-stage access is a write |
| pc_wdata_i | input | 32 | Write data in the PC stage |
| mem_addr_o | output | 16 | Program memory address (fetch stage) |
| mem_en_o | output | 1 | Program memory enable, set on a fetch-stage miss or write |
| mem_we_o | output | 1 | Program memory write strobe |
| mem_wdata_o | output | 32 | Program memory write data |
| mem_rdata_i | input | 32 | Program memory read word, valid in the same cycle as the enable |
| hit_o | output | 1 | Fetch-stage hit |
| dec_instr_o | output | 32 | Instruction word registered towards decode |

## Verification
The hardest situation to reach from the ports is the one in R8. A valid line must sit in the way the replacement bit points to. A read miss to another tag in the same set must be in the fetch stage. The old line's address must arrive in the PC stage in exactly that cycle. The directed stimulus gets there straight after reset: it fills the line into way 0, misses in the other set so the replacement bit stays on way 0 and the two reads are no longer adjacent, then misses in the first set, and presents the old address on the very next cycle. The replacement order of R5 and R6 is shown only through hit and miss patterns, using alternating set-1 hits to steer the replacement bit. A per-cycle reference model then checks long mixed read and write streams over a small pool of tags.

// File: rtl/icache_pkg.sv
// Package icache_pkg
// Shared constants and the fetch-stage access kind for the two-way
// instruction cache. Assumes exactly two ways, because replacement is one bit.
package icache_pkg;

    localparam int IC_ADDR_W   = 16;
    localparam int IC_DATA_W   = 32;
    localparam int IC_SET_BITS = 1;
    localparam int IC_WAYS     = 2;

    // What the fetch stage holds in a given cycle
    typedef enum logic [1:0] {
        FE_NONE  = 2'd0,   // nothing captured since reset
        FE_READ  = 2'd1,   // instruction fetch
        FE_WRITE = 2'd2    // program memory write
    } fe_kind_t;

endpackage

// File: rtl/icache_tag_way.sv
// Module icache_tag_way
// Tag and valid storage for one way. It has two compare ports: a lookup port
// for the PC-stage address and a check port for the fetch-stage address,
// which write updates use. A fill writes the tag and sets the valid bit.
// Assumes at most one fill per cycle. Only the valid bits are reset.
module icache_tag_way #(
    parameter int TAG_W    = 15,
    parameter int SET_BITS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] lk_idx,
    input  logic [TAG_W-1:0]    lk_tag,
    output logic                lk_match,
    input  logic [SET_BITS-1:0] chk_idx,
    input  logic [TAG_W-1:0]    chk_tag,
    output logic                chk_match,
    input  logic                fill_en,
    input  logic [SET_BITS-1:0] fill_idx,
    input  logic [TAG_W-1:0]    fill_tag,
    output logic [(1<<SET_BITS)-1:0] valid_o
);
    localparam int SETS = 1 << SET_BITS;

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  valid_q;

    // Valid bits: cleared by reset, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    // Tag storage: written on a fill
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx] <= fill_tag;
        end
    end

    // Compare ports: a valid line whose tag is equal
    always_comb begin
        lk_match  = valid_q[lk_idx]  && (tag_mem[lk_idx]  == lk_tag);
        chk_match = valid_q[chk_idx] && (tag_mem[chk_idx] == chk_tag);
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/icache_data_way.sv
// Module icache_data_way
// Instruction word storage for one way. It has one asynchronous read port
// and one write port. Assumes the write and the read may address the same
// set in one cycle; the read then returns the old word.
module icache_data_way #(
    parameter int DATA_W   = 32,
    parameter int SET_BITS = 1
) (
    input  logic                clk,
    input  logic [SET_BITS-1:0] rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [SET_BITS-1:0] wr_idx,
    input  logic [DATA_W-1:0]   wr_data
);
    localparam int SETS = 1 << SET_BITS;

    logic [DATA_W-1:0] word_mem [SETS];

    // Storage write: a fill or a write-through update
    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_mem[wr_idx] <= wr_data;
        end
    end

    // Read port for the fetch stage
    assign rd_data = word_mem[rd_idx];

endmodule

// File: rtl/icache_repl.sv
// Module icache_repl
// Single-bit replacement selector that names the way the next fill goes to.
// It inverts whenever the fetch stage reports a hit. Assumes two ways.
module icache_repl (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic sel_o
);
    logic sel_q;

    // Selector: way 0 after reset, flipped by each fetch-stage hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (adv_i) begin
            sel_q <= ~sel_q;
        end
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/icache_2way.sv
// Module icache_2way
// Two-way set-associative instruction cache with a PC stage (tag lookup)
// and a fetch stage (data select, fill, write-through).
// Assumes program memory answers a read in the same cycle as mem_en_o, and
// that one access enters the PC stage every clock after reset.
module icache_2way
    import icache_pkg::*;
#(
    parameter int ADDR_W   = IC_ADDR_W,
    parameter int DATA_W   = IC_DATA_W,
    parameter int SET_BITS = IC_SET_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_addr_i,
    input  logic              pc_we_i,
    input  logic [DATA_W-1:0] pc_wdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] dec_instr_o
);
    localparam int WAYS  = IC_WAYS;
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_BITS;
    localparam int SETS  = 1 << SET_BITS;
    localparam int LINES = WAYS * SETS;

    // PC-stage signals
    logic [SET_BITS-1:0] pc_idx;
    logic [TAG_W-1:0]    pc_tag;
    logic [WAYS-1:0]     lk_match;
    logic [WAYS-1:0]     way_hit;
    logic                pc_hit;
    logic [WAY_W-1:0]    pc_way;

    // Fetch-stage registers
    fe_kind_t            fe_kind_q;
    logic [ADDR_W-1:0]   fe_addr_q;
    logic [DATA_W-1:0]   fe_wdata_q;
    logic                fe_hit_q;
    logic [WAY_W-1:0]    fe_way_q;

    // Fetch-stage signals
    logic [SET_BITS-1:0] fe_idx;
    logic [TAG_W-1:0]    fe_tag;
    logic                fill_now;
    logic                fe_is_wr;
    logic [WAYS-1:0]     chk_match;
    logic [DATA_W-1:0]   way_rd [WAYS];
    logic [DATA_W-1:0]   fe_word;
    logic [DATA_W-1:0]   store_word;
    logic                repl_q;
    logic [DATA_W-1:0]   dec_q;
    logic [LINES-1:0]    line_valid;

    // Address split for both stages
    assign pc_idx = pc_addr_i[SET_BITS-1:0];
    assign pc_tag = pc_addr_i[ADDR_W-1:SET_BITS];
    assign fe_idx = fe_addr_q[SET_BITS-1:0];
    assign fe_tag = fe_addr_q[ADDR_W-1:SET_BITS];

    // Fetch-stage access classification
    assign fe_is_wr   = (fe_kind_q == FE_WRITE);
    assign fill_now   = (fe_kind_q == FE_READ) && !fe_hit_q;
    assign store_word = fe_is_wr ? fe_wdata_q : mem_rdata_i;

    // Per-way storage and PC-stage hit qualification
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WAY_ID = WAY_W'(w);
        logic fill_here;
        logic upd_here;
        logic evicting;

        assign fill_here = fill_now && (repl_q == WAY_ID);
        assign upd_here  = fe_is_wr && chk_match[w];
        assign evicting  = fill_here && (fe_idx == pc_idx);

        icache_tag_way #(
            .TAG_W    (TAG_W),
            .SET_BITS (SET_BITS)
        ) u_tag (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_idx    (pc_idx),
            .lk_tag    (pc_tag),
            .lk_match  (lk_match[w]),
            .chk_idx   (fe_idx),
            .chk_tag   (fe_tag),
            .chk_match (chk_match[w]),
            .fill_en   (fill_here),
            .fill_idx  (fe_idx),
            .fill_tag  (fe_tag),
            .valid_o   (line_valid[w*SETS +: SETS])
        );

        icache_data_way #(
            .DATA_W   (DATA_W),
            .SET_BITS (SET_BITS)
        ) u_data (
            .clk     (clk),
            .rd_idx  (fe_idx),
            .rd_data (way_rd[w]),
            .wr_en   (fill_here || upd_here),
            .wr_idx  (fe_idx),
            .wr_data (store_word)
        );

        // A write never hits; a line being replaced this cycle never hits
        assign way_hit[w] = lk_match[w] && !pc_we_i && !evicting;
    end

    // Encode which way hit in the PC stage
    always_comb begin
        pc_hit = |way_hit;
        pc_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                pc_way = WAY_W'(w);
            end
        end
    end

    // PC-to-fetch pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_kind_q  <= FE_NONE;
            fe_addr_q  <= '0;
            fe_wdata_q <= '0;
            fe_hit_q   <= 1'b0;
            fe_way_q   <= '0;
        end else begin
            fe_kind_q <= pc_we_i ? FE_WRITE : FE_READ;
            fe_addr_q <= pc_addr_i;
            fe_hit_q  <= pc_hit;
            if (pc_hit) begin
                fe_way_q <= pc_way;
            end
            if (pc_we_i) begin
                fe_wdata_q <= pc_wdata_i;
            end
        end
    end

    // Replacement selector, advanced by fetch-stage hits
    icache_repl u_repl (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (fe_hit_q),
        .sel_o (repl_q)
    );

    // Fetch-stage word: cached on a hit, memory on a miss
    assign fe_word = fe_hit_q ? way_rd[fe_way_q] : mem_rdata_i;

    // Decode register: loaded by reads only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else if (fe_kind_q == FE_READ) begin
            dec_q <= fe_word;
        end
    end

    // Program memory and status outputs
    assign mem_addr_o  = fe_addr_q;
    assign mem_en_o    = (fe_kind_q != FE_NONE) && !fe_hit_q;
    assign mem_we_o    = fe_is_wr;
    assign mem_wdata_o = fe_wdata_q;
    assign hit_o       = fe_hit_q;
    assign dec_instr_o = dec_q;

endmodule

// File: rtl/icache_2way_chk.sv
// Module icache_2way_chk
// Temporal checks on the two-way instruction cache, attached by bind.
// Assumes the replacement bit and the flattened valid bits of the top.
module icache_2way_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc_addr_i,
    input logic              pc_we_i,
    input logic [DATA_W-1:0] pc_wdata_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_en_o,
    input logic              mem_we_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              hit_o,
    input logic [DATA_W-1:0] dec_instr_o,
    input logic              repl_q,
    input logic [LINES-1:0]  line_valid
);

    // R1: reset leaves outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hit_o && !mem_en_o && (dec_instr_o == '0)));

    // R3: a read reaches the fetch stage with its address; memory only on a miss
    a_r3_read_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we_i |=> ((hit_o != mem_en_o) && !mem_we_o && (mem_addr_o == $past(pc_addr_i))));

    // R7: a write never hits and goes out to memory
    a_r7_write_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_i |=> (!hit_o && mem_en_o && mem_we_o));

    // R7: the write carries its own address and data
    a_r7_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_i |=> ((mem_addr_o == $past(pc_addr_i)) && (mem_wdata_o == $past(pc_wdata_i))));

    // R9: decode output holds across a write
    a_r9_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && mem_we_o) |=> $stable(dec_instr_o));

    // R6: a hit flips the replacement bit
    a_r6_repl_flip: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (repl_q != $past(repl_q)));

    // R6: no hit, no change
    a_r6_repl_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |=> $stable(repl_q));

    // R5: valid bits only grow, and only after a read miss
    a_r5_valid_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(line_valid) != $past($countones(line_valid))) |->
            (($countones(line_valid) > $past($countones(line_valid))) &&
             $past(mem_en_o && !mem_we_o)));

endmodule

bind icache_2way icache_2way_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_addr_i   (pc_addr_i),
    .pc_we_i     (pc_we_i),
    .pc_wdata_i  (pc_wdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .hit_o       (hit_o),
    .dec_instr_o (dec_instr_o),
    .repl_q      (repl_q),
    .line_valid  (line_valid)
);

// File: tb/tb_icache_2way.sv
// Bench for icache_2way: directed scenarios plus a mixed stream, compared
// every clock with a behavioural model of the cache and of program memory.
module tb_icache_2way;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_addr_i = '0;
    logic        pc_we_i = 1'b0;
    logic [31:0] pc_wdata_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_en_o;
    logic        mem_we_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        hit_o;
    logic [31:0] dec_instr_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    icache_2way dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_addr_i   (pc_addr_i),
        .pc_we_i     (pc_we_i),
        .pc_wdata_i  (pc_wdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_en_o    (mem_en_o),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .hit_o       (hit_o),
        .dec_instr_o (dec_instr_o)
    );

    always #5 clk = ~clk;

    // Program memory: a fixed pattern overlaid by written words
    logic [31:0] wmem [logic [15:0]];

    function automatic logic [31:0] memrd(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return {a ^ 16'h5A3C, ~a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Reference model state
    logic [14:0] m_tag [2][2];
    bit          m_val [2][2];
    logic [31:0] m_dat [2][2];
    int          m_repl;
    bit          f_live, f_we, f_hit;
    int          f_way;
    logic [15:0] f_addr;
    logic [31:0] f_wd;
    logic [31:0] exp_dec;
    int          ci, fi;
    bit          hh [2];
    bit          fill;

    // Model step on each clock edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 2; s++) m_val[w][s] = 0;
            m_repl = 0; f_live = 0; f_we = 0; f_hit = 0; f_way = 0;
            f_addr = '0; f_wd = '0; exp_dec = '0;
        end else begin
            ci = int'(pc_addr_i[0]);
            fill = f_live && !f_we && !f_hit;
            for (int w = 0; w < 2; w++)
                hh[w] = !pc_we_i && m_val[w][ci] && (m_tag[w][ci] == pc_addr_i[15:1])
                        && !(fill && (int'(f_addr[0]) == ci) && (m_repl == w));
            if (f_live) begin
                fi = int'(f_addr[0]);
                if (f_we) begin
                    for (int w = 0; w < 2; w++)
                        if (m_val[w][fi] && m_tag[w][fi] == f_addr[15:1]) m_dat[w][fi] = f_wd;
                end else if (f_hit) begin
                    exp_dec = m_dat[f_way][fi];
                    m_repl = 1 - m_repl;
                end else begin
                    m_tag[m_repl][fi] = f_addr[15:1];
                    m_val[m_repl][fi] = 1;
                    m_dat[m_repl][fi] = memrd(f_addr);
                    exp_dec = memrd(f_addr);
                end
            end
            f_live = 1; f_addr = pc_addr_i; f_we = pc_we_i; f_wd = pc_wdata_i;
            f_hit = hh[0] || hh[1];
            f_way = hh[1] ? 1 : 0;
        end
    end

    // Per-cycle comparison, then memory service, away from the clock edge
    always @(negedge clk) begin
        if (started) begin
            chk("R4 R8 hit flag", {31'd0, hit_o}, {31'd0, f_hit});
            chk("R3 memory enable", {31'd0, mem_en_o}, {31'd0, f_live && !f_hit});
            if (f_live && !f_hit) begin
                chk("R3 memory address", {16'd0, mem_addr_o}, {16'd0, f_addr});
                chk("R7 memory write strobe", {31'd0, mem_we_o}, {31'd0, f_we});
                if (f_we) chk("R7 memory write data", mem_wdata_o, f_wd);
            end
            chk("R9 decode word", dec_instr_o, exp_dec);
        end
        if (mem_en_o === 1'b1 && mem_we_o === 1'b1) wmem[mem_addr_o] = mem_wdata_o;
        mem_rdata_i = memrd(mem_addr_o);
    end

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Present one access; return once it occupies the fetch stage
    task automatic acc(input logic [15:0] a, input bit we = 0, input logic [31:0] d = '0);
        pc_addr_i = a; pc_we_i = we; pc_wdata_i = d;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    localparam logic [15:0] P = 16'h0400, Q = 16'h0500, N = 16'h0600;
    localparam logic [15:0] Z = 16'h0201, Y = 16'h0100, X = 16'h0300, W = 16'h0700;
    localparam logic [31:0] D = 32'hC0DE_1234;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset hit", {31'd0, hit_o}, 32'd0);
        chk("R1 reset enable", {31'd0, mem_en_o}, 32'd0);
        chk("R1 reset decode", dec_instr_o, 32'd0);
        rst_n = 1;

        // R5 and R6: fill order and the hit-driven replacement bit
        acc(P); chk("R1 first read misses", {31'd0, hit_o}, 32'd0);
        acc(Z);
        acc(P); chk("R6 resident line hits", {31'd0, hit_o}, 32'd1);
        acc(Q); chk("R5 second tag misses", {31'd0, hit_o}, 32'd0);
        acc(Z);
        acc(P); chk("R5 way 0 still holds P", {31'd0, hit_o}, 32'd1);
        acc(Q); chk("R5 way 1 holds Q", {31'd0, hit_o}, 32'd1);
        acc(Z);
        acc(N); chk("R5 third tag misses", {31'd0, hit_o}, 32'd0);
        acc(Z);
        acc(P); chk("R6 way 0 kept by selector", {31'd0, hit_o}, 32'd1);
        acc(Z);
        acc(Q); chk("R6 way 1 replaced", {31'd0, hit_o}, 32'd0);

        // R7 and R9: write-through update, no allocation, decode held
        do_reset();
        acc(P); acc(Z); acc(P);
        acc(P, 1, D);
        chk("R7 write not a hit", {31'd0, hit_o}, 32'd0);
        chk("R7 write strobe", {31'd0, mem_we_o & mem_en_o}, 32'd1);
        acc(Z);
        chk("R9 decode held over write", dec_instr_o, {P ^ 16'h5A3C, ~P});
        acc(P); chk("R7 updated line hits", {31'd0, hit_o}, 32'd1);
        acc(Z); chk("R7 updated word", dec_instr_o, D);
        acc(W, 1, 32'h0BAD_F00D);
        acc(Z);
        acc(W); chk("R7 write did not allocate", {31'd0, hit_o}, 32'd0);
        acc(Z); chk("R7 read after write", dec_instr_o, 32'h0BAD_F00D);

        // R8: hit on a line being overwritten is a miss
        do_reset();
        acc(Y); acc(Z); acc(X);
        acc(Y); chk("R8 evicted line misses", {31'd0, hit_o}, 32'd0);
        acc(Z); chk("R8 word from memory", dec_instr_o, {Y ^ 16'h5A3C, ~Y});

        // R2: set bit and tag bits both separate lines
        do_reset();
        acc(P); acc(Z); acc(P);
        acc(16'h0401); chk("R2 other set misses", {31'd0, hit_o}, 32'd0);
        acc(16'h8400); chk("R2 other tag misses", {31'd0, hit_o}, 32'd0);

        // Mixed stream over a small tag pool
        for (int i = 0; i < 4000; i++) begin
            int t;
            logic [14:0] tg;
            t = int'($urandom % 6);
            tg = 15'(t * 37 + 3);
            acc({tg, 1'($urandom % 2)}, ($urandom % 8) == 0, $urandom);
        end
        acc(Z); acc(Z);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule